// File: doc/BRIEF.md
# Four-Slot Frame-Synchronous Codec Serial Port

This block is the serial port of a codec-style device. It acts as clock master. It divides its master clock into a bit clock and makes a frame sync pulse once every 64 bit clocks. Each frame carries four 16-bit time slots in each direction. Slots 0 and 1 carry the left and right audio samples. Slot 2 carries a command that accesses a small bank of 8-bit index registers. Slot 3 carries a status word towards the remote device.

Received words pass through a 16-bit shift register. Each finished word is held and then copied into its per-slot buffer register a fixed 8 bit clocks after its last bit. Transmit words are loaded into an output shift register at the start of their slot and shifted out MSB first. An index read is answered within the same frame. The register address arrives in the upper half of the slot 2 command, so the port can place the addressed register's contents in the lower half of its own slot 2 output word.

Top module: `tdm_codec_port`

## Requirements
- R1: `sclk` is high for N master clock cycles and then low for N cycles, where N is `div_n`. A value of 0 is treated as 1. `sclk` is low out of reset.
- R2: A frame is 64 bit clocks long. `fsync` is high for exactly one bit clock, the last one of each frame, and it changes only together with a rising edge of `sclk`.
- R3: `sdout` changes only on a rising edge of `sclk`. `sdin` is sampled on the falling edge of `sclk`. Both directions send and receive words MSB first, so bit 15 goes in the first bit clock of a slot.
- R4: In reset, `sclk`, `fsync`, `sdout`, `rx_left` and `rx_right` are 0 and every index register is 0. After reset the first bit clock is slot 0, bit 15. Until the first `fsync` pulse, `sdout` stays low and serial input is discarded.
- R5: Output slot 0 carries `tx_left`, slot 1 carries `tx_right` and slot 3 carries `tx_status`. Each value is taken at the start of its slot.
- R6: Input slot 0 is written to `rx_left` and input slot 1 to `rx_right`. The write happens on the falling `sclk` edge exactly 8 bit clocks after the word's last bit was sampled, which is bit clock 23 for slot 0 and bit clock 39 for slot 1.
- R7: The input slot 2 command is laid out as follows: bit 15 = 1 means write, bits 12:8 are the address and bits 7:0 are the data. A write lands 8 bit clocks after the word ends. A write to an address above 20 is ignored.
- R8: Output slot 2 has bits 15:8 at zero. Bits 7:0 hold the content of the register addressed by that frame's slot 2 command, as it was before that command's own write. An address above 20 reads as 0.
- R9: Input slot 3 is ignored. It changes neither the buffer registers nor the index registers, whatever its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_n | input | DIV_W | Bit clock half-period in master cycles |
| sdin | input | 1 | Serial data input |
| tx_left | input | 16 | Left word sent in slot 0 |
| tx_right | input | 16 | Right word sent in slot 1 |
| tx_status | input | 16 | Status word sent in slot 3 |
| sclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync pulse |
| sdout | output | 1 | Serial data output |
| rx_left | output | 16 | Left input buffer register |
| rx_right | output | 16 | Right input buffer register |

## Verification
The assertions check the following on every cycle:
- the bit clock's half period against `div_n`;
- that `fsync` and `sdout` move only on rising bit clock edges;
- that the buffer registers move only on falling edges;
- that the output line stays quiet before the first frame sync.

The bench's scenarios cover the rest:
- the slot contents and MSB-first bit order;
- the exact 8-bit-clock load delay;
- the same-frame read-back of old register contents;
- the handling of addresses above 20;
- that slot 3 input has no effect.

// File: rtl/tdm_codec_port.sv
`timescale 1ns/1ps
module tdm_codec_port #(
  parameter int DIV_W     = 8,
  parameter int IDX_DEPTH = 21,
  parameter int IDX_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_n,
  input  logic             sdin,
  input  logic [15:0]      tx_left,
  input  logic [15:0]      tx_right,
  input  logic [15:0]      tx_status,
  output logic             sclk,
  output logic             fsync,
  output logic             sdout,
  output logic [15:0]      rx_left,
  output logic [15:0]      rx_right
);
  localparam int W      = 16;
  localparam int AW     = 5;
  localparam int RB_POS = 2 * W + (W - IDX_W);

  logic [DIV_W-1:0] cnt;
  logic [5:0]       pos;
  logic             seen, live;
  logic [W-1:0]     isr, osr, hold;
  logic [1:0]       hold_slot;
  logic             hold_vld;
  logic [IDX_W-1:0] regs [IDX_DEPTH];

  wire [DIV_W-1:0] half = (div_n == '0) ? DIV_W'(1) : div_n;
  wire             tick = (cnt >= half - DIV_W'(1));
  wire             rise = tick & ~sclk;
  wire             fall = tick & sclk;
  wire [5:0]       npos = pos + 6'd1;
  wire [AW-1:0]    cmd_addr = isr[AW-1:0];
  wire [IDX_W-1:0] rd_data  = (32'(cmd_addr) < IDX_DEPTH) ? regs[cmd_addr] : '0;
  wire [W-1:0]     shifted_in = {isr[W-2:0], sdin};

  logic [W-1:0] slot_word;
  always_comb begin
    case (npos[5:4])
      2'd0:    slot_word = tx_left;
      2'd1:    slot_word = tx_right;
      2'd2:    slot_word = '0;
      default: slot_word = tx_status;
    endcase
  end

  assign fsync = seen && (pos == 6'd63);
  assign sdout = live & osr[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
      pos  <= 6'd63;
      seen <= 1'b0;
      live <= 1'b0;
      osr  <= '0;
    end else begin
      cnt <= tick ? '0 : cnt + DIV_W'(1);
      if (tick) sclk <= ~sclk;
      if (rise) begin
        pos  <= npos;
        seen <= 1'b1;
        if (fsync) live <= 1'b1;
        if (npos[3:0] == 4'd0)       osr <= slot_word;
        else if (npos == 6'(RB_POS)) osr <= {rd_data, {(W-IDX_W){1'b0}}};
        else                         osr <= {osr[W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr       <= '0;
      hold      <= '0;
      hold_slot <= '0;
      hold_vld  <= 1'b0;
      rx_left   <= '0;
      rx_right  <= '0;
      for (int i = 0; i < IDX_DEPTH; i++) regs[i] <= '0;
    end else if (fall) begin
      isr <= shifted_in;
      if (pos[3:0] == 4'd15) begin
        hold      <= shifted_in;
        hold_slot <= pos[5:4];
        hold_vld  <= live;
      end
      if (pos[3:0] == 4'd7 && hold_vld) begin
        case (hold_slot)
          2'd0: rx_left  <= hold;
          2'd1: rx_right <= hold;
          2'd2: if (hold[W-1] && 32'(hold[12:8]) < IDX_DEPTH)
                  regs[hold[12:8]] <= hold[IDX_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

module tdm_codec_port_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] div_n,
  input logic             sclk,
  input logic             fsync,
  input logic             sdout,
  input logic [15:0]      rx_left,
  input logic [15:0]      rx_right
);
  logic             prev_sclk, fs_seen, prev_fs;
  logic [DIV_W:0]   run;
  wire  [DIV_W:0]   half = (div_n == '0) ? (DIV_W+1)'(1) : {1'b0, div_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sclk <= 1'b0;
      run       <= '0;
      fs_seen   <= 1'b0;
      prev_fs   <= 1'b0;
    end else begin
      prev_sclk <= sclk;
      prev_fs   <= fsync;
      if (prev_fs && !fsync) fs_seen <= 1'b1;
      if (sclk != prev_sclk)   run <= (DIV_W+1)'(1);
      else if (run != '1)      run <= run + (DIV_W+1)'(1);
    end
  end

  p_half_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != prev_sclk) |-> (run == half));
  p_fsync_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fsync) |-> $rose(sclk));
  p_sdout_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout) |-> $rose(sclk));
  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fs_seen && !$fell(fsync)) |-> !sdout);
  p_rx_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(rx_left) || !$stable(rx_right)) |-> $fell(sclk));
endmodule

bind tdm_codec_port tdm_codec_port_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .div_n(div_n), .sclk(sclk), .fsync(fsync),
  .sdout(sdout), .rx_left(rx_left), .rx_right(rx_right)
);

// File: tb/tdm_codec_port_bench.sv
`timescale 1ns/1ps
module tdm_codec_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  div_n = 8'd2;
  logic        sdin = 1'b0;
  logic [15:0] tx_left = '0, tx_right = '0, tx_status = '0;
  logic        sclk, fsync, sdout;
  logic [15:0] rx_left, rx_right;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] got [4];
  logic [15:0] rxl_hist [64];
  logic [15:0] rxr_hist [64];

  always #2 clk = ~clk;

  tdm_codec_port u_tdm_codec_port (
    .clk(clk), .rst_n(rst_n), .div_n(div_n), .sdin(sdin),
    .tx_left(tx_left), .tx_right(tx_right), .tx_status(tx_status),
    .sclk(sclk), .fsync(fsync), .sdout(sdout),
    .rx_left(rx_left), .rx_right(rx_right)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] n);
    rst_n = 1'b0;
    div_n = n;
    sdin  = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic run_frame(input logic [15:0] w0, w1, w2, w3);
    logic [15:0] words [4];
    words = '{w0, w1, w2, w3};
    while (!fsync) begin @(posedge sclk); #1; end
    for (int p = 0; p < 64; p++) begin
      @(posedge sclk); #1;
      sdin = words[p/16][15 - (p % 16)];
      @(negedge sclk); #1;
      got[p/16][15 - (p % 16)] = sdout;
      rxl_hist[p] = rx_left;
      rxr_hist[p] = rx_right;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R4 sclk in reset", 32'(sclk), 0);
    check("R4 fsync in reset", 32'(fsync), 0);
    check("R4 sdout in reset", 32'(sdout), 0);
    check("R4 rx_left in reset", 32'(rx_left), 0);
    check("R4 rx_right in reset", 32'(rx_right), 0);
  endtask

  task automatic t_first_frame;
    int hi = 0;
    tx_left = 16'hFFFF; tx_right = 16'hFFFF; tx_status = 16'hFFFF;
    do_reset(8'd2);
    for (int p = 0; p < 64; p++) begin
      @(posedge sclk); #1;
      sdin = 1'b1;
      @(negedge sclk); #1;
      if (sdout) hi++;
    end
    check("R4 sdout low before first fsync", 32'(hi), 0);
    check("R4 fsync at end of first frame", 32'(fsync), 1);
    run_frame(16'h0000, 16'h0000, 16'h0000, 16'h0000);
    check("R4 input before first fsync discarded", 32'(rxl_hist[22]), 0);
  endtask

  task automatic t_audio;
    tx_left = 16'hA5C3; tx_right = 16'h1234; tx_status = 16'hBEEF;
    run_frame(16'h8001, 16'h7FFE, 16'h0000, 16'h0000);
    check("R5 slot0 left word", 32'(got[0]), 32'hA5C3);
    check("R5 slot1 right word", 32'(got[1]), 32'h1234);
    check("R5 slot3 status word", 32'(got[3]), 32'hBEEF);
    check("R6 rx_left", 32'(rx_left), 32'h8001);
    check("R6 rx_right", 32'(rx_right), 32'h7FFE);
  endtask

  task automatic t_ibr_delay;
    tx_left = 16'h0F0F; tx_right = 16'hC001;
    run_frame(16'h4C21, 16'h0381, 16'h0000, 16'h0000);
    check("R6 rx_left old at bit 22", 32'(rxl_hist[22]), 32'h8001);
    check("R6 rx_left new at bit 23", 32'(rxl_hist[23]), 32'h4C21);
    check("R6 rx_right old at bit 38", 32'(rxr_hist[38]), 32'h7FFE);
    check("R6 rx_right new at bit 39", 32'(rxr_hist[39]), 32'h0381);
    check("R3 MSB first out slot0", 32'(got[0]), 32'h0F0F);
    check("R3 MSB first out slot1", 32'(got[1]), 32'hC001);
  endtask

  task automatic t_index;
    run_frame(16'h0, 16'h0, 16'h853C, 16'h0);
    check("R8 write frame returns old value", 32'(got[2]), 32'h0000);
    run_frame(16'h0, 16'h0, 16'h0500, 16'h0);
    check("R8 same-frame read addr 5", 32'(got[2]), 32'h003C);
    run_frame(16'h0, 16'h0, 16'h94A7, 16'h0);
    check("R7 write addr 20 frame", 32'(got[2]), 32'h0000);
    run_frame(16'h0, 16'h0, 16'h95FF, 16'h0);
    check("R8 addr 21 reads zero", 32'(got[2]), 32'h0000);
    run_frame(16'h0, 16'h0, 16'h1400, 16'h0);
    check("R7 read back addr 20", 32'(got[2]), 32'h00A7);
    run_frame(16'h0, 16'h0, 16'h1500, 16'h0);
    check("R7 write to addr 21 ignored", 32'(got[2]), 32'h0000);
    run_frame(16'h0, 16'h0, 16'h8511, 16'h0);
    check("R8 overwrite shows prior value", 32'(got[2]), 32'h003C);
    run_frame(16'h0, 16'h0, 16'h0500, 16'h0);
    check("R7 overwrite landed", 32'(got[2]), 32'h0011);
  endtask

  task automatic t_slot3_ignored;
    run_frame(16'h1111, 16'h2222, 16'h0A00, 16'h8A55);
    run_frame(16'h1111, 16'h2222, 16'h0A00, 16'hFFFF);
    check("R9 slot3 no index write", 32'(got[2]), 32'h0000);
    check("R9 rx_left unchanged by slot3", 32'(rx_left), 32'h1111);
    check("R9 rx_right unchanged by slot3", 32'(rx_right), 32'h2222);
    check("R9 rx_left not hit at next bit 7", 32'(rxl_hist[7]), 32'h1111);
  endtask

  task automatic t_divider(input logic [7:0] n);
    realtime t0, t1, t2;
    int eff, k;
    eff = (n == 0) ? 1 : int'(n);
    do_reset(n);
    @(posedge sclk); t0 = $realtime;
    @(negedge sclk); t1 = $realtime;
    @(posedge sclk); t2 = $realtime;
    check("R1 sclk high time", 32'(int'((t1 - t0) / 4.0)), 32'(eff));
    check("R1 sclk period", 32'(int'((t2 - t0) / 4.0)), 32'(2 * eff));
    @(posedge fsync);
    k = 0;
    for (int i = 0; i < 200; i++) begin
      @(posedge sclk); #1;
      k++;
      if (fsync) break;
    end
    check("R2 frame length in bit clocks", 32'(k), 64);
    @(posedge sclk); #1;
    check("R2 fsync one bit clock wide", 32'(fsync), 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_first_frame();
    t_audio();
    t_ibr_delay();
    t_index();
    t_slot3_ignored();
    t_divider(8'd1);
    t_divider(8'd3);
    t_divider(8'd0);
    t_audio();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule